// File: doc/BRIEF.md
# Ping-Pong Parity Memory Scrubber

This block keeps two on-chip RAM banks, called flip and flop, that hold copies of one data array. It sits on the input side of a streaming computation. Each accepted stream index reads one word from one bank and checks its parity. The word is handed downstream and is then written back into the other bank at the same address. The copy direction swaps between odd and even indices, so ordinary traffic keeps both banks refreshed. No word is ever rewritten in place.

A preload port fills both banks with the same word and a parity bit supplied by the caller. A supplied parity bit that is wrong is stored as given, so a corrupted word can be planted deliberately. A sticky, saturating counter records how many words were flagged, and a synchronous clear input resets it.

Top module: `pingpong_scrubber`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `out_valid` and `out_err` are 0 and `err_count` is 0.
- R2: The stream index is ADDR_W+1 bits wide. Bank address = `in_idx[ADDR_W:1]`. An odd index (`in_idx[0]`=1) reads the flip bank and copies into the flop bank. An even index reads the flop bank and copies into the flip bank.
- R3: An accepted strobe (`in_valid`=1 with `pl_valid`=0) raises `out_valid` for exactly one cycle, in the cycle after the strobe. `out_data` then carries the 32 data bits of the word read.
- R4: The copy into the opposite bank is written at the same address in the cycle after the read, using the 33-bit word exactly as read.
- R5: A stored word is 32 data bits plus one even-parity bit (bit 32). `out_err` is 1 exactly when `out_valid` is 1 and the XOR of all 33 bits read is 1.
- R6: A preload (`pl_valid`=1) writes `{pl_parity, pl_data}` into both banks at `pl_addr`. A scrub of any index of that address then returns `pl_data`.
- R7: Preload has priority over scrub traffic. A strobe in a preload cycle is ignored and produces no `out_valid`. A copy falling in a preload cycle is discarded, so the preloaded word survives in both banks.
- R8: `err_count` counts cycles with `out_err`=1, one cycle after each, and saturates at 2^CNT_W-1.
- R9: `cnt_clr` clears `err_count` to 0 on the next clock edge and wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream index strobe |
| in_idx | input | ADDR_W+1 | Stream index; bit 0 selects direction |
| pl_valid | input | 1 | Preload strobe |
| pl_addr | input | ADDR_W | Preload bank address |
| pl_data | input | DATA_W | Preload data word |
| pl_parity | input | 1 | Preload parity bit, stored as given |
| cnt_clr | input | 1 | Synchronous clear of the error counter |
| out_valid | output | 1 | Output word valid |
| out_data | output | DATA_W | Data bits of the word read |
| out_err | output | 1 | Parity error on the word read |
| err_count | output | CNT_W | Saturating count of flagged words |

## Verification
The bench preloads every address of a 16-deep configuration. Three of the addresses carry a deliberately wrong parity bit. It then streams all 32 indices back to back, first ascending and then descending. The ascending pass checks the data, the flag and the exact error total. The descending pass reads each bank after the other bank has copied into it, and drives the counter into saturation. A strobe inside a preload cycle shows whether preload blocks the access. A preload placed right after an odd read, followed by reads of both indices of that address, shows whether the stale copy was discarded or wrongly landed a cycle late. Counter clears are applied both alone and in the same cycle as a flagged word.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic {
    DIR_FLOP_TO_FLIP = 1'b0,
    DIR_FLIP_TO_FLOP = 1'b1
  } scrub_dir_e;
endpackage

// File: rtl/scrub_bank.sv
module scrub_bank #(
  parameter int WORD_W = 33,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // simple dual-port, read-first, registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/scrub_err_count.sv
module scrub_err_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)                 count <= '0;
    else if (inc && count != CNT_MAX) count <= count + 1'b1;
  end

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX && !clr) |=> count == CNT_MAX);
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0);
  p_step_r8: assert property (@(posedge clk) disable iff (rst)
    (!clr && inc && count != CNT_MAX) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/pingpong_scrubber.sv
module pingpong_scrubber
  import scrub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W:0]   in_idx,
  input  logic              pl_valid,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [DATA_W-1:0] pl_data,
  input  logic              pl_parity,
  input  logic              cnt_clr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err,
  output logic [CNT_W-1:0]  err_count
);
  localparam int WORD_W = DATA_W + 1;

  // access acceptance: preload wins
  logic              acc;
  logic [ADDR_W-1:0] acc_addr;
  scrub_dir_e        acc_dir;

  assign acc      = in_valid && !pl_valid;
  assign acc_addr = in_idx[ADDR_W:1];
  assign acc_dir  = scrub_dir_e'(in_idx[0]);

  // read stage tracking (word appears one cycle after the strobe)
  logic              s1_valid;
  logic [ADDR_W-1:0] s1_addr;
  scrub_dir_e        s1_dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_addr  <= '0;
      s1_dir   <= DIR_FLOP_TO_FLIP;
    end else begin
      s1_valid <= acc;
      if (acc) begin
        s1_addr <= acc_addr;
        s1_dir  <= acc_dir;
      end
    end
  end

  // bank ports
  logic              flip_we, flop_we, flip_re, flop_re;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_word, flip_q, flop_q, rd_word;

  assign flip_re = acc && (acc_dir == DIR_FLIP_TO_FLOP);
  assign flop_re = acc && (acc_dir == DIR_FLOP_TO_FLIP);

  assign rd_word = (s1_dir == DIR_FLIP_TO_FLOP) ? flip_q : flop_q;

  // write-back of the word as read, preload overrides
  assign flop_we = pl_valid || (s1_valid && s1_dir == DIR_FLIP_TO_FLOP);
  assign flip_we = pl_valid || (s1_valid && s1_dir == DIR_FLOP_TO_FLIP);
  assign wr_addr = pl_valid ? pl_addr : s1_addr;
  assign wr_word = pl_valid ? {pl_parity, pl_data} : rd_word;

  scrub_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_flip (
    .clk(clk), .we(flip_we), .waddr(wr_addr), .wdata(wr_word),
    .re(flip_re), .raddr(acc_addr), .rdata(flip_q)
  );

  scrub_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_flop (
    .clk(clk), .we(flop_we), .waddr(wr_addr), .wdata(wr_word),
    .re(flop_re), .raddr(acc_addr), .rdata(flop_q)
  );

  assign out_valid = s1_valid;
  assign out_data  = rd_word[DATA_W-1:0];
  assign out_err   = s1_valid && (^rd_word);

  scrub_err_count #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(out_err), .count(err_count)
  );

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);
  p_no_access_r7: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !out_valid);
  p_err_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    out_err |-> out_valid);
  p_wb_odd_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && in_idx[0]) |=> (pl_valid || (flop_we && !flip_we && wr_addr == $past(acc_addr))));
  p_wb_even_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && !in_idx[0]) |=> (pl_valid || (flip_we && !flop_we && wr_addr == $past(acc_addr))));
endmodule

// File: tb/test_pingpong_scrubber.sv
module test_pingpong_scrubber;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int CW = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [AW:0]   in_idx = '0;
  logic          pl_valid = 1'b0;
  logic [AW-1:0] pl_addr = '0;
  logic [DW-1:0] pl_data = '0;
  logic          pl_parity = 1'b0;
  logic          cnt_clr = 1'b0;
  logic          out_valid, out_err;
  logic [DW-1:0] out_data;
  logic [CW-1:0] err_count;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  pingpong_scrubber #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) i_pingpong_scrubber (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_idx(in_idx),
    .pl_valid(pl_valid), .pl_addr(pl_addr), .pl_data(pl_data),
    .pl_parity(pl_parity), .cnt_clr(cnt_clr), .out_valid(out_valid),
    .out_data(out_data), .out_err(out_err), .err_count(err_count)
  );

  function automatic logic [DW-1:0] word_of(int a);
    return (32'(a) + 32'd1) * 32'h9E37_79B1;
  endfunction

  function automatic logic bad_of(int a);
    return (a % 5) == 3;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic preload(int a, logic [DW-1:0] d, logic bad);
    pl_valid  = 1'b1;
    pl_addr   = AW'(a);
    pl_data   = d;
    pl_parity = (^d) ^ bad;
    @(posedge clk); @(negedge clk);
    pl_valid = 1'b0;
  endtask

  // one streaming access; leaves in_valid low unless the caller drives it again
  task automatic scrub(int idx, logic [DW-1:0] exp_d, logic exp_e, string req);
    in_valid = 1'b1;
    in_idx   = (AW+1)'(idx);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, 64'(out_valid), 64'd1);
    chk({req, " data"},  64'(out_data),  64'(exp_d));
    chk({req, " err R5"}, 64'(out_err),  64'(exp_e));
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int exp_cnt;
    @(negedge clk);
    // R1: outputs during reset
    chk("R1 valid in reset", 64'(out_valid), 64'd0);
    chk("R1 count in reset", 64'(err_count), 64'd0);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 valid after reset", 64'(out_valid), 64'd0);
    chk("R1 err after reset", 64'(out_err), 64'd0);
    chk("R1 count after reset", 64'(err_count), 64'd0);

    // R6: preload every address, some with a planted parity error
    for (int a = 0; a < DEPTH; a++) preload(a, word_of(a), bad_of(a));

    // R2 R3 R4 R5: ascending sweep, streamed back to back
    exp_cnt = 0;
    for (int i = 0; i < 2*DEPTH; i++) begin
      scrub(i, word_of(i >> 1), bad_of(i >> 1), (i % 2) ? "R2 odd flip read" : "R2 even flop read");
      if (bad_of(i >> 1)) exp_cnt++;
    end
    idle();
    chk("R8 count after ascending sweep", 64'(err_count), 64'(exp_cnt));

    // R4: descending sweep reads each bank after the other copied into it
    for (int i = 2*DEPTH-1; i >= 0; i--) begin
      scrub(i, word_of(i >> 1), bad_of(i >> 1), "R4 copy preserved");
      if (bad_of(i >> 1)) exp_cnt++;
    end
    idle();
    chk("R8 saturated count", 64'(err_count), 64'((exp_cnt > 7) ? 7 : exp_cnt));

    // R9: plain clear
    cnt_clr = 1'b1;
    idle();
    cnt_clr = 1'b0;
    chk("R9 clear", 64'(err_count), 64'd0);

    // R9: clear in the same cycle as a flagged word
    scrub(6, word_of(3), 1'b1, "R9 flagged access");
    cnt_clr = 1'b1;
    idle();
    cnt_clr = 1'b0;
    chk("R9 clear beats increment", 64'(err_count), 64'd0);
    scrub(7, word_of(3), 1'b1, "R8 flagged access");
    idle();
    chk("R8 single increment", 64'(err_count), 64'd1);

    // R7: strobe during preload is ignored
    in_valid  = 1'b1;
    in_idx    = 5'd9;
    pl_valid  = 1'b1;
    pl_addr   = 4'd10;
    pl_data   = 32'hCAFE_0001;
    pl_parity = ^32'hCAFE_0001;
    idle();
    in_valid = 1'b0;
    pl_valid = 1'b0;
    chk("R7 strobe ignored", 64'(out_valid), 64'd0);
    scrub(21, 32'hCAFE_0001, 1'b0, "R6 preloaded flip");
    scrub(20, 32'hCAFE_0001, 1'b0, "R6 preloaded flop");

    // R7 R4: preload right after an odd read discards the copy
    in_valid = 1'b1;
    in_idx   = 5'd11;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk("R3 read word", 64'(out_data), 64'(word_of(5)));
    pl_valid  = 1'b1;
    pl_addr   = 4'd5;
    pl_data   = 32'h1234_5678;
    pl_parity = ^32'h1234_5678;
    idle();
    pl_valid = 1'b0;
    idle();
    scrub(10, 32'h1234_5678, 1'b0, "R7 copy discarded flop");
    scrub(11, 32'h1234_5678, 1'b0, "R7 copy discarded flip");
    idle();
    chk("R3 single-cycle valid", 64'(out_valid), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule